// File: doc/BRIEF.md
# Receive Signalling Debounce and Freeze

This block keeps the validated receive signalling state of 24 voice channels on a digital trunk. Upstream framing logic hands it single signalling bits, each tagged with the frame number inside the multiframe (1 to 24) and the channel number (0 to 23). The block gathers the bits of each channel into a nibble. When the last signalling frame of the multiframe arrives, it offers that nibble to a per-channel debounce stage. A value that passes the debounce is stored and can be read back through a combinational read port.

Stored values must not be corrupted while the framer is hunting. All updates stop while the multiframe sync flag is low. They also stop from the moment a reframe is requested until the sync flag rises again.

A change in any stored nibble sets one pending interrupt. This drives an interrupt line when the enable is set and presents a fixed vector code. Reading the vector clears the pending state. The debounce length is counted in millisecond ticks and depends on the line mode.

Top module: `rx_sig_debounce`

## Requirements
- R1: In 24-frame mode (`cfg_ab_only`=0), the bits from frames 6, 12, 18 and 24 land in nibble bits 3, 2, 1 and 0 respectively. The nibble is offered for update when the frame 24 bit arrives.
- R2: In 12-frame mode (`cfg_ab_only`=1), only frames 6 and 12 are used, landing in bits 3 and 2. The nibble is offered at frame 12, with bits 1 and 0 stored as 0. Bits tagged frame 18 or 24 change nothing.
- R3: While `mf_sync` is low, incoming bits and millisecond ticks have no effect, and every stored nibble keeps its value.
- R4: A one-cycle `reframe_req` blocks all updates from that cycle until the next rising edge of `mf_sync`, even if `mf_sync` stays high.
- R5: With debounce disabled, the offered nibble is stored on the clock edge that accepts the last signalling bit.
- R6: With debounce enabled and `cfg_long_db`=0, an offered value that differs from the stored one is stored on the 6th `ms_tick` after it was offered. Offering a different value restarts the count. Outside an update or a tick, stored nibbles do not change.
- R7: With debounce enabled and `cfg_long_db`=1, the required persistence is 14 ticks.
- R8: Any change of a stored nibble sets a pending flag. While the flag is set, `vec_o` reads 8'h01; otherwise it reads 8'h00. `irq_o` is high only when the flag is set and `cfg_irq_en` is 1. Offering a value equal to the stored one raises nothing.
- R9: A one-cycle `vec_rd` with no simultaneous change clears the pending flag, so `irq_o` drops and `vec_o` returns to 8'h00.
- R10: After reset, all stored nibbles are 0. `rd_nibble` shows the stored nibble of `rd_chan` combinationally, and reads 0 for channel numbers 24 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A signalling bit is presented this cycle |
| smp_frame | input | 5 | Frame number of the bit within the multiframe (1..24) |
| smp_chan | input | 5 | Channel number of the bit (0..23) |
| smp_bit | input | 1 | Signalling bit value |
| mf_sync | input | 1 | Multiframe synchronization present |
| reframe_req | input | 1 | One-cycle reframe request |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| cfg_ab_only | input | 1 | 1 selects 12-frame mode with two bits per channel |
| cfg_debounce_en | input | 1 | Enable debounce |
| cfg_long_db | input | 1 | 1 selects the 14-tick period, 0 the 6-tick period |
| cfg_irq_en | input | 1 | Interrupt enable |
| rd_chan | input | 5 | Channel selected for readback |
| rd_nibble | output | 4 | Stored nibble of the selected channel |
| vec_rd | input | 1 | One-cycle vector read strobe |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Interrupt vector |

## Verification
The hardest situation to reach is a pending debounce candidate that is partway through its count when updates are blocked, followed by the count resuming after sync returns. The bench offers a new value to a channel, drops the sync flag, and issues many ticks that must all be ignored. It then restores sync and issues exactly six ticks, checking that nothing is stored before the sixth. The restart rule is reached by offering a second, different value partway through a count. The reframe hold is reached by requesting a reframe while sync stays high.

// File: rtl/rsd_pkg.sv
// Shared constants for the receive signalling debounce block.
// Assumes four signalling bit slots per multiframe, spaced six frames apart.
package rsd_pkg;
    localparam int SIG_W      = 4;   // bits per channel nibble
    localparam int SLOT_PITCH = 6;   // frames between signalling slots
    localparam logic [7:0] SIG_VECTOR = 8'h01;
endpackage

// File: rtl/rsd_freeze_ctl.sv
// Update-hold control: blocks signalling updates while multiframe sync is
// absent, and from a reframe request until the next rising edge of sync.
// Assumes reframe_req is a single-cycle pulse.
module rsd_freeze_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic mf_sync,
    input  logic reframe_req,
    output logic frozen
);
    logic hold_q;
    logic sync_q;

    // Track the previous sync level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= mf_sync;
    end

    // Reframe hold: a request sets it, a sync rising edge releases it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_q <= 1'b0;
        else if (reframe_req)       hold_q <= 1'b1;
        else if (mf_sync && !sync_q) hold_q <= 1'b0;
    end

    // Combined freeze condition, including the request cycle itself.
    always_comb frozen = hold_q || reframe_req || !mf_sync;
endmodule

// File: rtl/rsd_chan.sv
// One channel: gathers signalling bits into a nibble, debounces the nibble
// against the stored value using a candidate and a tick counter, and flags
// each change of the stored value. Assumes db_len >= 1.
module rsd_chan #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frozen,
    input  logic             bit_we,
    input  logic [1:0]       bit_pos,
    input  logic             bit_val,
    input  logic             commit,
    input  logic             ab_only,
    input  logic             db_en,
    input  logic [CNT_W-1:0] db_len,
    input  logic             ms_tick,
    output logic [3:0]       stored,
    output logic             chg
);
    logic [3:0]       asm_q, merged, sample;
    logic [3:0]       cand_q, nxt_st, nxt_cand;
    logic [CNT_W-1:0] cnt_q, nxt_cnt;

    // Merge the arriving bit into the gathered nibble (slot 0 -> bit 3).
    always_comb begin
        merged = asm_q;
        if (bit_we) merged[3 - bit_pos] = bit_val;
        sample = ab_only ? {merged[3:2], 2'b00} : merged;
    end

    // Hold gathered bits between slots.
    always_ff @(posedge clk) begin
        if (!rst_n)                asm_q <= '0;
        else if (bit_we && !frozen) asm_q <= merged;
    end

    // Next-state of stored value, candidate and persistence counter.
    always_comb begin
        nxt_st   = stored;
        nxt_cand = cand_q;
        nxt_cnt  = cnt_q;
        chg      = 1'b0;
        if (!frozen) begin
            if (commit && !db_en) begin
                nxt_st   = sample;
                nxt_cand = sample;
                nxt_cnt  = '0;
                chg      = (sample != stored);
            end else if (commit && (sample != cand_q)) begin
                nxt_cand = sample;
                nxt_cnt  = '0;
            end else if (ms_tick && db_en) begin
                if (cand_q == stored) begin
                    nxt_cnt = '0;
                end else if (cnt_q >= db_len - 1'b1) begin
                    nxt_st  = cand_q;
                    nxt_cnt = '0;
                    chg     = 1'b1;
                end else begin
                    nxt_cnt = cnt_q + 1'b1;
                end
            end
        end
    end

    // Register the debounce state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
            cand_q <= '0;
            cnt_q  <= '0;
        end else begin
            stored <= nxt_st;
            cand_q <= nxt_cand;
            cnt_q  <= nxt_cnt;
        end
    end
endmodule

// File: rtl/rsd_irq.sv
// Change-of-state interrupt: one pending flag for all channels, a masked
// request line and a fixed vector. A new change wins over a clearing read.
module rsd_irq #(
    parameter logic [7:0] VEC_CODE = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chg_any,
    input  logic       vec_rd,
    input  logic       irq_en,
    output logic       pend,
    output logic       irq_o,
    output logic [7:0] vec_o
);
    // Pending flag: set by any change, cleared by a vector read.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (chg_any) pend <= 1'b1;
        else if (vec_rd)  pend <= 1'b0;
    end

    // Masked request and vector presentation.
    always_comb begin
        irq_o = pend && irq_en;
        vec_o = pend ? VEC_CODE : 8'h00;
    end
endmodule

// File: rtl/rx_sig_debounce.sv
// Receive signalling store for NUM_CH channels: decodes the frame slot of
// each arriving bit, routes it to its channel, applies debounce and freeze,
// and drives the readback port and the change interrupt.
// Assumes at most one signalling bit per cycle.
module rx_sig_debounce #(
    parameter int NUM_CH    = 24,
    parameter int FRM_W     = 5,
    parameter int DB_T1_MS  = 6,
    parameter int DB_E1_MS  = 14,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int CNT_W    = $clog2(DB_E1_MS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [FRM_W-1:0] smp_frame,
    input  logic [CH_W-1:0]  smp_chan,
    input  logic             smp_bit,
    input  logic             mf_sync,
    input  logic             reframe_req,
    input  logic             ms_tick,
    input  logic             cfg_ab_only,
    input  logic             cfg_debounce_en,
    input  logic             cfg_long_db,
    input  logic             cfg_irq_en,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [3:0]       rd_nibble,
    input  logic             vec_rd,
    output logic             irq_o,
    output logic [7:0]       vec_o
);
    import rsd_pkg::*;

    logic                     frozen;
    logic                     slot_hit, pos_ok, commit_any, chg_any, irq_pend;
    logic [1:0]               slot_pos;
    logic [CNT_W-1:0]         db_len;
    logic [3:0]               st_arr [NUM_CH];
    logic [NUM_CH-1:0]        chg_vec;
    logic [NUM_CH*SIG_W-1:0]  store_flat;

    // Decode the frame number into a slot position and the commit point.
    always_comb begin
        slot_hit = 1'b0;
        slot_pos = 2'd0;
        for (int k = 0; k < SIG_W; k++) begin
            if (smp_frame == FRM_W'(SLOT_PITCH * (k + 1))) begin
                slot_hit = 1'b1;
                slot_pos = 2'(k);
            end
        end
        pos_ok     = smp_valid && slot_hit && (!cfg_ab_only || !slot_pos[1]);
        commit_any = pos_ok && (slot_pos == (cfg_ab_only ? 2'd1 : 2'd3));
        db_len     = cfg_long_db ? CNT_W'(DB_E1_MS) : CNT_W'(DB_T1_MS);
    end

    rsd_freeze_ctl u_freeze (
        .clk         (clk),
        .rst_n       (rst_n),
        .mf_sync     (mf_sync),
        .reframe_req (reframe_req),
        .frozen      (frozen)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = pos_ok && (smp_chan == CH_W'(i));
        rsd_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .frozen  (frozen),
            .bit_we  (sel),
            .bit_pos (slot_pos),
            .bit_val (smp_bit),
            .commit  (sel && commit_any),
            .ab_only (cfg_ab_only),
            .db_en   (cfg_debounce_en),
            .db_len  (db_len),
            .ms_tick (ms_tick),
            .stored  (st_arr[i]),
            .chg     (chg_vec[i])
        );
        assign store_flat[i*SIG_W +: SIG_W] = st_arr[i];
    end

    // Aggregate change events and select the readback nibble.
    always_comb begin
        chg_any   = |chg_vec;
        rd_nibble = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (rd_chan == CH_W'(i)) rd_nibble = st_arr[i];
    end

    rsd_irq #(.VEC_CODE(SIG_VECTOR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .chg_any (chg_any),
        .vec_rd  (vec_rd),
        .irq_en  (cfg_irq_en),
        .pend    (irq_pend),
        .irq_o   (irq_o),
        .vec_o   (vec_o)
    );
endmodule

// File: rtl/rsd_checker.sv
// Property checker for rx_sig_debounce, attached by bind.
module rsd_checker #(
    parameter int NUM_CH = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frozen,
    input logic              commit_any,
    input logic              ms_tick,
    input logic [NUM_CH*4-1:0] store_flat,
    input logic              chg_any,
    input logic              irq_pend,
    input logic              vec_rd,
    input logic              cfg_irq_en,
    input logic              irq_o,
    input logic [7:0]        vec_o
);
    // R3: a frozen cycle leaves every stored nibble unchanged.
    p_frozen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(store_flat));
    // R6: without an update point or a tick, nothing stored moves.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_any && !ms_tick) |=> $stable(store_flat));
    // R8: a change leaves the pending flag set.
    p_change_pends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_any |=> irq_pend);
    // R8: the request line stays low while disabled.
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq_o);
    // R8: an active request always presents the fixed code.
    p_vector_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o == 8'h01));
    // R9: a read with no competing change clears the request.
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !chg_any) |=> (!irq_o && vec_o == 8'h00));
endmodule

bind rx_sig_debounce rsd_checker #(.NUM_CH(NUM_CH)) u_rsd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frozen     (frozen),
    .commit_any (commit_any),
    .ms_tick    (ms_tick),
    .store_flat (store_flat),
    .chg_any    (chg_any),
    .irq_pend   (irq_pend),
    .vec_rd     (vec_rd),
    .cfg_irq_en (cfg_irq_en),
    .irq_o      (irq_o),
    .vec_o      (vec_o)
);

// File: tb/rx_sig_debounce_bench.sv
module rx_sig_debounce_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic [4:0] smp_frame = '0;
    logic [4:0] smp_chan = '0;
    logic       smp_bit = 1'b0;
    logic       mf_sync = 1'b1;
    logic       reframe_req = 1'b0;
    logic       ms_tick = 1'b0;
    logic       cfg_ab_only = 1'b0;
    logic       cfg_debounce_en = 1'b0;
    logic       cfg_long_db = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic [4:0] rd_chan = '0;
    logic [3:0] rd_nibble;
    logic       vec_rd = 1'b0;
    logic       irq_o;
    logic [7:0] vec_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rx_sig_debounce u_rx_sig_debounce (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_frame(smp_frame),
        .smp_chan(smp_chan), .smp_bit(smp_bit), .mf_sync(mf_sync),
        .reframe_req(reframe_req), .ms_tick(ms_tick), .cfg_ab_only(cfg_ab_only),
        .cfg_debounce_en(cfg_debounce_en), .cfg_long_db(cfg_long_db),
        .cfg_irq_en(cfg_irq_en), .rd_chan(rd_chan), .rd_nibble(rd_nibble),
        .vec_rd(vec_rd), .irq_o(irq_o), .vec_o(vec_o)
    );

    // {ab_only, channel, offered nibble, expected stored nibble}
    localparam logic [13:0] TV [6] = '{
        {1'b0, 5'd0,  4'hA, 4'hA},
        {1'b0, 5'd23, 4'h5, 4'h5},
        {1'b1, 5'd7,  4'hF, 4'hC},
        {1'b1, 5'd7,  4'h6, 4'h4},
        {1'b0, 5'd7,  4'h6, 4'h6},
        {1'b0, 5'd12, 4'h3, 4'h3}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Send all four slot bits of one multiframe for a channel.
    task automatic send_mf(input logic [4:0] ch, input logic [3:0] nib);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_frame = 5'(6 * (k + 1));
            smp_chan  = ch;
            smp_bit   = nib[3 - k];
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [4:0] ch, output logic [3:0] v);
        rd_chan = ch;
        #1;
        v = rd_nibble;
    endtask

    task automatic read_vec;
        @(negedge clk); vec_rd = 1'b1;
        @(negedge clk); vec_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int c = 0; c < 24; c += 7) begin
            rd(5'(c), v); chk("R10 reset nibble", v, 0);
        end
        chk("R8 reset irq", irq_o, 0);
        chk("R8 reset vector", vec_o, 0);

        // R1 R2 R5: vector table, debounce off
        for (int i = 0; i < 6; i++) begin
            cfg_ab_only = TV[i][13];
            send_mf(TV[i][12:8], TV[i][7:4]);
            rd(TV[i][12:8], v);
            chk(TV[i][13] ? "R2 twelve-frame slots" : "R1 R5 slot order", v, TV[i][3:0]);
        end
        cfg_ab_only = 1'b0;
        rd(5'd0, v);  chk("R1 other channel kept", v, 4'hA);
        rd(5'd30, v); chk("R10 out-of-range read", v, 0);
        chk("R8 masked irq", irq_o, 0);
        chk("R8 vector pending", vec_o, 8'h01);
        read_vec;
        chk("R9 vector cleared", vec_o, 8'h00);

        // R6: short debounce and restart
        cfg_debounce_en = 1'b1;
        send_mf(5'd3, 4'h5);
        rd(5'd3, v); chk("R6 not yet stored", v, 0);
        tick(5);
        rd(5'd3, v); chk("R6 after 5 ticks", v, 0);
        tick(1);
        rd(5'd3, v); chk("R6 after 6 ticks", v, 4'h5);
        send_mf(5'd3, 4'hA);
        tick(3);
        send_mf(5'd3, 4'h9);
        tick(5);
        rd(5'd3, v); chk("R6 restart holds", v, 4'h5);
        tick(1);
        rd(5'd3, v); chk("R6 restart accepted", v, 4'h9);

        // R7: long debounce
        cfg_long_db = 1'b1;
        send_mf(5'd3, 4'h2);
        tick(13);
        rd(5'd3, v); chk("R7 after 13 ticks", v, 4'h9);
        tick(1);
        rd(5'd3, v); chk("R7 after 14 ticks", v, 4'h2);
        cfg_long_db = 1'b0;

        // R3: candidate pending while sync lost
        send_mf(5'd5, 4'h7);
        @(negedge clk); mf_sync = 1'b0;
        tick(10);
        rd(5'd5, v); chk("R3 ticks ignored", v, 0);
        @(negedge clk); mf_sync = 1'b1;
        tick(5);
        rd(5'd5, v); chk("R3 count resumes", v, 0);
        tick(1);
        rd(5'd5, v); chk("R3 accepted after resume", v, 4'h7);

        // R3: direct updates blocked while sync lost
        cfg_debounce_en = 1'b0;
        @(negedge clk); mf_sync = 1'b0;
        send_mf(5'd4, 4'hF);
        rd(5'd4, v); chk("R3 bits ignored", v, 0);
        @(negedge clk); mf_sync = 1'b1;
        send_mf(5'd4, 4'hF);
        rd(5'd4, v); chk("R3 updates after sync", v, 4'hF);

        // R4: reframe hold with sync kept high
        @(negedge clk); reframe_req = 1'b1;
        @(negedge clk); reframe_req = 1'b0;
        send_mf(5'd4, 4'h1);
        rd(5'd4, v); chk("R4 hold after reframe", v, 4'hF);
        @(negedge clk); mf_sync = 1'b0;
        @(negedge clk); mf_sync = 1'b1;
        send_mf(5'd4, 4'h1);
        rd(5'd4, v); chk("R4 released by sync", v, 4'h1);

        // R8 R9: interrupt behaviour
        read_vec;
        cfg_irq_en = 1'b1;
        @(negedge clk);
        chk("R9 cleared before enable", irq_o, 0);
        send_mf(5'd6, 4'h3);
        chk("R8 irq on change", irq_o, 1);
        chk("R8 vector code", vec_o, 8'h01);
        read_vec;
        chk("R9 irq cleared", irq_o, 0);
        send_mf(5'd6, 4'h3);
        chk("R8 no irq on same value", irq_o, 0);
        send_mf(5'd6, 4'h0);
        chk("R8 irq on revert", irq_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule